// File: doc/BRIEF.md
# Parallel Port Transfer FIFO with Mode Control

This block sits between a host register interface and the eight data lines of a parallel printer port. A sixteen-entry byte queue buffers traffic. A mode-control register selects how the port behaves, reports whether the queue is empty or full, and enables a service interrupt. The threshold for that interrupt depends on the transfer direction.

In the automatic output mode, a transmit sequencer takes bytes from the head of the queue and sends them with the classic strobe, busy and acknowledge handshake. In the test mode, the host can fill and empty the queue and the head byte appears on the data lines, but no strobe is ever issued. A second interrupt output follows either the fault input or the acknowledge input. A bit of the control register selects which one.

Top module: `pport_ecp_fifo`

## Requirements
- R1: After reset the control register reads 8'h21: mode 3'b001 in bits 7:5, bit 0 (queue empty) = 1, all other bits 0. svcIrq and extIrq are 0 and strobeN is 1.
- R2: The queue holds 16 bytes in first-in first-out order. Host writes are accepted in modes 3'b010, 3'b011 and 3'b110. Host reads are accepted in modes 3'b011 and 3'b110. fifoRdData always shows the oldest byte.
- R3: Register bit 0 is 1 exactly when the queue holds no byte. Bit 1 is 1 exactly when it holds 16 bytes. A write to a full queue or a read from an empty queue is dropped and changes no stored byte or flag.
- R4: A register write loads the mode from bits 7:5. If both the current and the requested mode lie outside {3'b000, 3'b001}, the mode field keeps its old value while bits 4 and 2 are still written. Bit 3 always reads 0.
- R5: When bit 2 is 0 and the mode is 3'b010, 3'b011 or 3'b110, the service condition is checked every cycle. In the forward direction (dirIn = 0, and always in mode 3'b010) the condition is at least 4 free entries. In the reverse direction (dirIn = 1) it is at least 12 stored bytes. When the condition holds, bit 2 is set to 1 and svcIrq rises on the following clock edge. In the other modes svcIrq stays 0.
- R6: A register write clears svcIrq on its clock edge. Writing 1 to bit 2 never raises svcIrq.
- R7: extIrq is registered one cycle from the selected source. With bit 4 = 0 it follows the inverted faultN input. With bit 4 = 1 it follows the inverted ackN input. The unselected input has no effect.
- R8: In mode 3'b010 the sequencer works as follows. It waits until the queue holds a byte and periphBusy is 0. It then drives that byte on pdOut and keeps strobeN high for SETUP_CYCLES cycles. Next it holds strobeN low for strobeCycles cycles. It then waits, with pdOut held, until ackN is 0, pops the byte, and waits for ackN to return to 1 before starting the next byte.
- R9: In mode 3'b110, strobeN stays 1 and pdOut shows the oldest queued byte.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| ecrWrEn | input | 1 | Control register write strobe |
| ecrWrData | input | 8 | Control register write value |
| ecrRdData | output | 8 | Control register read value |
| fifoWrEn | input | 1 | Host push strobe |
| fifoWrData | input | 8 | Byte to push |
| fifoRdEn | input | 1 | Host pop strobe |
| fifoRdData | output | 8 | Oldest queued byte |
| dirIn | input | 1 | Port direction, 1 = reverse |
| strobeCycles | input | 4 | Strobe low width in cycles (0 acts as 1) |
| periphBusy | input | 1 | Peripheral not ready, active high |
| ackN | input | 1 | Peripheral acknowledge, active low |
| faultN | input | 1 | Peripheral fault, active low |
| pdOut | output | 8 | Data toward the port lines |
| strobeN | output | 1 | Data strobe, active low |
| svcIrq | output | 1 | Service interrupt |
| extIrq | output | 1 | Fault or acknowledge interrupt |

## Verification
The assertions assume that the host never pops in the automatic output mode, where the sequencer owns the read side. They also assume that the peripheral returns ackN only after a strobe. The stimulus keeps to both. Host reads are issued only in the test mode, and the acknowledge is driven low only after a strobe pulse has been observed to end. Mode changes in the stimulus pass through 3'b001 except for one deliberate illegal request. Every push and pop in the stimulus is a single-cycle strobe issued away from the clock edge.

// File: rtl/pport_pkg.sv
package pport_pkg;

  typedef enum logic [2:0] {
    MODE_STD      = 3'b000,
    MODE_BYTE     = 3'b001,
    MODE_FIFO_OUT = 3'b010,
    MODE_ECP      = 3'b011,
    MODE_EPP      = 3'b100,
    MODE_RSVD     = 3'b101,
    MODE_TEST     = 3'b110,
    MODE_CFG      = 3'b111
  } portMode_e;

  typedef struct packed {
    logic push;
    logic pop;
  } fifoStrobe_t;

  typedef enum logic [2:0] {
    TX_IDLE,
    TX_SETUP,
    TX_STROBE,
    TX_WAITACK,
    TX_RELEASE
  } txState_e;

endpackage

// File: rtl/pport_fifo_dp.sv
module pport_fifo_dp
  import pport_pkg::*;
#(
  parameter int WIDTH = 8,
  parameter int DEPTH = 16,
  localparam int AW = $clog2(DEPTH),
  localparam int CW = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rstN,
  input  fifoStrobe_t      strb,
  input  logic [WIDTH-1:0] wrData,
  output logic [WIDTH-1:0] headData,
  output logic [CW-1:0]    level,
  output logic             full,
  output logic             empty
);

  logic [WIDTH-1:0] slot [DEPTH];
  logic [AW-1:0]    wrPtr;
  logic [AW-1:0]    rdPtr;
  logic             doPush;
  logic             doPop;

  assign full   = (level == CW'(DEPTH));
  assign empty  = (level == '0);
  assign doPush = strb.push && !full;
  assign doPop  = strb.pop && !empty;

  // one register per entry, loaded when the write pointer selects it
  for (genvar i = 0; i < DEPTH; i++) begin : g_slot
    always_ff @(posedge clk) begin
      if (doPush && (wrPtr == AW'(i))) begin
        slot[i] <= wrData;
      end
    end
  end

  assign headData = slot[rdPtr];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      wrPtr <= '0;
      rdPtr <= '0;
      level <= '0;
    end else begin
      if (doPush) begin
        wrPtr <= (wrPtr == AW'(DEPTH - 1)) ? '0 : wrPtr + 1'b1;
      end
      if (doPop) begin
        rdPtr <= (rdPtr == AW'(DEPTH - 1)) ? '0 : rdPtr + 1'b1;
      end
      case ({doPush, doPop})
        2'b10:   level <= level + 1'b1;
        2'b01:   level <= level - 1'b1;
        default: level <= level;
      endcase
    end
  end

  assert_level_bound_R2: assert property (@(posedge clk) disable iff (!rstN)
    level <= CW'(DEPTH));

  assert_no_overflow_R3: assert property (@(posedge clk) disable iff (!rstN)
    (full && strb.push && !strb.pop) |=> (level == $past(level)));

  assert_no_underflow_R3: assert property (@(posedge clk) disable iff (!rstN)
    (empty && strb.pop && !strb.push) |=> empty);

endmodule

// File: rtl/pport_fifo_ctrl.sv
module pport_fifo_ctrl
  import pport_pkg::*;
#(
  parameter int WIDTH         = 8,
  parameter int DEPTH         = 16,
  parameter int FWD_FREE_THR  = 4,
  parameter int REV_AVAIL_THR = 12,
  parameter int SETUP_CYCLES  = 2,
  parameter int STRB_CW       = 4,
  localparam int CW      = $clog2(DEPTH + 1),
  localparam int SETUP_W = $clog2(SETUP_CYCLES + 1),
  localparam int CNT_W   = (SETUP_W > STRB_CW) ? SETUP_W : STRB_CW
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               ecrWrEn,
  input  logic [7:0]         ecrWrData,
  output logic [7:0]         ecrRdData,
  input  logic               fifoWrEn,
  input  logic               fifoRdEn,
  input  logic               dirIn,
  input  logic [STRB_CW-1:0] strobeCycles,
  input  logic               periphBusy,
  input  logic               ackN,
  input  logic               faultN,
  input  logic [WIDTH-1:0]   headData,
  input  logic [CW-1:0]      level,
  input  logic               full,
  input  logic               empty,
  output fifoStrobe_t        strb,
  output logic [WIDTH-1:0]   pdOut,
  output logic               strobeN,
  output logic               svcIrq,
  output logic               extIrq
);

  localparam logic [CW:0] FREE_THR  = (CW + 1)'(FWD_FREE_THR);
  localparam logic [CW:0] AVAIL_THR = (CW + 1)'(REV_AVAIL_THR);
  localparam logic [CW:0] DEPTH_EXT = (CW + 1)'(DEPTH);

  portMode_e        modeQ;
  logic             errSrcQ;
  logic             svcOffQ;
  logic             svcIrqQ;
  logic             extIrqQ;
  txState_e         txState;
  logic [CNT_W-1:0] txCnt;
  logic [WIDTH-1:0] txData;

  portMode_e        reqMode;
  logic             modeOk;
  logic             fifoMode;
  logic             hostRdMode;
  logic             dirEff;
  logic             fwdHit;
  logic             revHit;
  logic             svcCond;
  logic             seqPop;
  logic [CNT_W-1:0] strobeLoad;

  function automatic logic isBase(portMode_e m);
    return (m == MODE_STD) || (m == MODE_BYTE);
  endfunction

  // ---------------- mode register ----------------
  assign reqMode    = portMode_e'(ecrWrData[7:5]);
  assign modeOk     = isBase(modeQ) || isBase(reqMode);
  assign fifoMode   = (modeQ == MODE_FIFO_OUT) || (modeQ == MODE_ECP) || (modeQ == MODE_TEST);
  assign hostRdMode = (modeQ == MODE_ECP) || (modeQ == MODE_TEST);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      modeQ   <= MODE_BYTE;
      errSrcQ <= 1'b0;
    end else if (ecrWrEn) begin
      errSrcQ <= ecrWrData[4];
      if (modeOk) begin
        modeQ <= reqMode;
      end
    end
  end

  assign ecrRdData = {modeQ, errSrcQ, 1'b0, svcOffQ, full, empty};

  // ---------------- queue strobes ----------------
  assign seqPop   = (txState == TX_WAITACK) && !ackN;
  assign strb.push = fifoWrEn && fifoMode;
  assign strb.pop  = (fifoRdEn && hostRdMode) || seqPop;

  // ---------------- service interrupt ----------------
  assign dirEff  = (modeQ == MODE_FIFO_OUT) ? 1'b0 : dirIn;
  assign fwdHit  = (DEPTH_EXT - {1'b0, level}) >= FREE_THR;
  assign revHit  = {1'b0, level} >= AVAIL_THR;
  assign svcCond = fifoMode && (dirEff ? revHit : fwdHit);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      svcOffQ <= 1'b0;
      svcIrqQ <= 1'b0;
    end else if (ecrWrEn) begin
      svcOffQ <= ecrWrData[2];
      svcIrqQ <= 1'b0;
    end else if (!svcOffQ && svcCond) begin
      svcOffQ <= 1'b1;
      svcIrqQ <= 1'b1;
    end
  end

  assign svcIrq = svcIrqQ;

  // ---------------- fault / acknowledge interrupt ----------------
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      extIrqQ <= 1'b0;
    end else begin
      extIrqQ <= errSrcQ ? !ackN : !faultN;
    end
  end

  assign extIrq = extIrqQ;

  // ---------------- transmit sequencer ----------------
  assign strobeLoad = (strobeCycles == '0) ? '0 : CNT_W'(strobeCycles - 1'b1);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      txState <= TX_IDLE;
      txCnt   <= '0;
      txData  <= '0;
    end else if (modeQ != MODE_FIFO_OUT) begin
      txState <= TX_IDLE;
      txCnt   <= '0;
    end else begin
      case (txState)
        TX_IDLE: begin
          if (!empty && !periphBusy) begin
            txData  <= headData;
            txCnt   <= CNT_W'(SETUP_CYCLES - 1);
            txState <= TX_SETUP;
          end
        end
        TX_SETUP: begin
          if (txCnt == '0) begin
            txCnt   <= strobeLoad;
            txState <= TX_STROBE;
          end else begin
            txCnt <= txCnt - 1'b1;
          end
        end
        TX_STROBE: begin
          if (txCnt == '0) begin
            txState <= TX_WAITACK;
          end else begin
            txCnt <= txCnt - 1'b1;
          end
        end
        TX_WAITACK: begin
          if (!ackN) begin
            txState <= TX_RELEASE;
          end
        end
        TX_RELEASE: begin
          if (ackN) begin
            txState <= TX_IDLE;
          end
        end
        default: txState <= TX_IDLE;
      endcase
    end
  end

  assign strobeN = (txState != TX_STROBE);
  assign pdOut   = (modeQ == MODE_TEST) ? headData : txData;

  // ---------------- assertions ----------------
  assert_mode_path_R4: assert property (@(posedge clk) disable iff (!rstN)
    (modeQ != $past(modeQ)) |-> (isBase($past(modeQ)) || isBase(modeQ)));

  assert_bit3_zero_R4: assert property (@(posedge clk) disable iff (!rstN)
    ecrRdData[3] == 1'b0);

  assert_svc_origin_R6: assert property (@(posedge clk) disable iff (!rstN)
    $rose(svcIrq) |-> ($past(!svcOffQ) && !$past(ecrWrEn)));

  assert_svc_mode_R5: assert property (@(posedge clk) disable iff (!rstN)
    $rose(svcIrq) |-> $past(fifoMode));

  assert_strobe_mode_R8: assert property (@(posedge clk) disable iff (!rstN)
    !strobeN |-> (modeQ == MODE_FIFO_OUT));

  assert_strobe_after_setup_R8: assert property (@(posedge clk) disable iff (!rstN)
    $fell(strobeN) |-> ($past(txState) == TX_SETUP));

  assert_data_hold_R8: assert property (@(posedge clk) disable iff (!rstN)
    ((txState == TX_STROBE) || (txState == TX_WAITACK)) |-> $stable(txData));

  assert_no_test_strobe_R9: assert property (@(posedge clk) disable iff (!rstN)
    (modeQ == MODE_TEST) |-> strobeN);

endmodule

// File: rtl/pport_ecp_fifo.sv
module pport_ecp_fifo
  import pport_pkg::*;
#(
  parameter int WIDTH         = 8,
  parameter int DEPTH         = 16,
  parameter int FWD_FREE_THR  = 4,
  parameter int REV_AVAIL_THR = 12,
  parameter int SETUP_CYCLES  = 2,
  parameter int STRB_CW       = 4,
  localparam int CW = $clog2(DEPTH + 1)
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               ecrWrEn,
  input  logic [7:0]         ecrWrData,
  output logic [7:0]         ecrRdData,
  input  logic               fifoWrEn,
  input  logic [WIDTH-1:0]   fifoWrData,
  input  logic               fifoRdEn,
  output logic [WIDTH-1:0]   fifoRdData,
  input  logic               dirIn,
  input  logic [STRB_CW-1:0] strobeCycles,
  input  logic               periphBusy,
  input  logic               ackN,
  input  logic               faultN,
  output logic [WIDTH-1:0]   pdOut,
  output logic               strobeN,
  output logic               svcIrq,
  output logic               extIrq
);

  fifoStrobe_t      strb;
  logic [WIDTH-1:0] headData;
  logic [CW-1:0]    level;
  logic             full;
  logic             empty;

  pport_fifo_dp #(
    .WIDTH (WIDTH),
    .DEPTH (DEPTH)
  ) dp_i (
    .clk      (clk),
    .rstN     (rstN),
    .strb     (strb),
    .wrData   (fifoWrData),
    .headData (headData),
    .level    (level),
    .full     (full),
    .empty    (empty)
  );

  pport_fifo_ctrl #(
    .WIDTH         (WIDTH),
    .DEPTH         (DEPTH),
    .FWD_FREE_THR  (FWD_FREE_THR),
    .REV_AVAIL_THR (REV_AVAIL_THR),
    .SETUP_CYCLES  (SETUP_CYCLES),
    .STRB_CW       (STRB_CW)
  ) ctrl_i (
    .clk          (clk),
    .rstN         (rstN),
    .ecrWrEn      (ecrWrEn),
    .ecrWrData    (ecrWrData),
    .ecrRdData    (ecrRdData),
    .fifoWrEn     (fifoWrEn),
    .fifoRdEn     (fifoRdEn),
    .dirIn        (dirIn),
    .strobeCycles (strobeCycles),
    .periphBusy   (periphBusy),
    .ackN         (ackN),
    .faultN       (faultN),
    .headData     (headData),
    .level        (level),
    .full         (full),
    .empty        (empty),
    .strb         (strb),
    .pdOut        (pdOut),
    .strobeN      (strobeN),
    .svcIrq       (svcIrq),
    .extIrq       (extIrq)
  );

  assign fifoRdData = headData;

endmodule

// File: tb/pport_ecp_fifo_tb_top.sv
module pport_ecp_fifo_tb_top;

  localparam int SETUP = 2;
  localparam int SWID  = 3;

  logic       clk = 1'b0;
  logic       rstN;
  logic       ecrWrEn = 1'b0;
  logic [7:0] ecrWrData = '0;
  logic [7:0] ecrRdData;
  logic       fifoWrEn = 1'b0;
  logic [7:0] fifoWrData = '0;
  logic       fifoRdEn = 1'b0;
  logic [7:0] fifoRdData;
  logic       dirIn = 1'b0;
  logic [3:0] strobeCycles = 4'(SWID);
  logic       periphBusy = 1'b0;
  logic       ackN = 1'b1;
  logic       faultN = 1'b1;
  logic [7:0] pdOut;
  logic       strobeN;
  logic       svcIrq;
  logic       extIrq;

  int total = 0;
  int fails = 0;

  always #5 clk = ~clk;

  pport_ecp_fifo #(.SETUP_CYCLES(SETUP)) dut_i (
    .clk(clk), .rstN(rstN),
    .ecrWrEn(ecrWrEn), .ecrWrData(ecrWrData), .ecrRdData(ecrRdData),
    .fifoWrEn(fifoWrEn), .fifoWrData(fifoWrData),
    .fifoRdEn(fifoRdEn), .fifoRdData(fifoRdData),
    .dirIn(dirIn), .strobeCycles(strobeCycles),
    .periphBusy(periphBusy), .ackN(ackN), .faultN(faultN),
    .pdOut(pdOut), .strobeN(strobeN), .svcIrq(svcIrq), .extIrq(extIrq)
  );

  task automatic tick();
    @(posedge clk);
    #1;
  endtask

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic ecrWrite(input logic [7:0] v);
    ecrWrEn = 1'b1;
    ecrWrData = v;
    tick();
    ecrWrEn = 1'b0;
  endtask

  task automatic push(input logic [7:0] v);
    fifoWrEn = 1'b1;
    fifoWrData = v;
    tick();
    fifoWrEn = 1'b0;
  endtask

  task automatic pop(output logic [7:0] v);
    v = fifoRdData;
    fifoRdEn = 1'b1;
    tick();
    fifoRdEn = 1'b0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    total++;
    fails++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end

  initial begin
    logic [7:0] got;
    logic [7:0] txBytes [3];
    bit ok;
    int n;
    int w;

    rstN = 1'b0;
    repeat (3) tick();
    rstN = 1'b1;
    tick();

    // R1 reset state
    chk(ecrRdData == 8'h21, "R1 reset register", ecrRdData, 8'h21);
    chk(svcIrq == 1'b0 && extIrq == 1'b0, "R1 reset interrupts", {svcIrq, extIrq}, 0);
    chk(strobeN == 1'b1, "R1 reset strobe", strobeN, 1);

    // R5 no service interrupt outside queue modes
    ecrWrite(8'h20);
    tick();
    tick();
    chk(svcIrq == 1'b0, "R5 byte mode no service", svcIrq, 0);

    // R3/R5/R6 sweep of every level in test mode
    ecrWrite(8'hC4);
    for (int k = 0; k <= 16; k++) begin
      chk(ecrRdData[0] == (k == 0), "R3 empty flag", ecrRdData[0], (k == 0));
      chk(ecrRdData[1] == (k == 16), "R3 full flag", ecrRdData[1], (k == 16));
      for (int d = 0; d < 2; d++) begin
        bit exp;
        dirIn = d[0];
        ecrWrite(8'hC0);
        tick();
        exp = (d == 1) ? (k >= 12) : ((16 - k) >= 4);
        chk(svcIrq == exp, "R5 service threshold", svcIrq, exp);
        chk(ecrRdData[2] == exp, "R5 service bit", ecrRdData[2], exp);
        ecrWrite(8'hC4);
        chk(svcIrq == 1'b0, "R6 write clears service", svcIrq, 0);
      end
      if (k < 16) push(8'(k * 11 + 5));
    end
    dirIn = 1'b0;
    push(8'hEE);
    chk(ecrRdData[1:0] == 2'b10, "R3 push to full dropped", ecrRdData[1:0], 2);
    for (int k = 0; k < 16; k++) begin
      pop(got);
      chk(got == 8'(k * 11 + 5), "R2 order", got, 8'(k * 11 + 5));
    end
    chk(ecrRdData[1:0] == 2'b01, "R3 empty after drain", ecrRdData[1:0], 1);
    pop(got);
    chk(ecrRdData[1:0] == 2'b01, "R3 pop from empty dropped", ecrRdData[1:0], 1);
    push(8'h77);
    pop(got);
    chk(got == 8'h77, "R3 pointers intact after drop", got, 8'h77);

    // R6 writing one to the service bit with the condition true
    ok = 1'b1;
    ecrWrite(8'hC4);
    for (int i = 0; i < 4; i++) begin
      tick();
      if (svcIrq) ok = 1'b0;
    end
    chk(ok, "R6 set bit raises nothing", !ok, 0);

    // R8 automatic transmit
    ecrWrite(8'h24);
    ecrWrite(8'h44);
    chk(ecrRdData[7:5] == 3'b010, "R4 mode via base", ecrRdData[7:5], 2);
    periphBusy = 1'b1;
    txBytes[0] = 8'hA5;
    txBytes[1] = 8'h3C;
    txBytes[2] = 8'h0F;
    for (int i = 0; i < 3; i++) push(txBytes[i]);
    ok = 1'b1;
    for (int i = 0; i < 8; i++) begin
      tick();
      if (!strobeN) ok = 1'b0;
    end
    chk(ok, "R8 held while busy", !ok, 0);
    periphBusy = 1'b0;
    for (int b = 0; b < 3; b++) begin
      n = 0;
      while (strobeN && n < 50) begin
        tick();
        n++;
      end
      if (b == 0) chk(n == 1 + SETUP, "R8 setup delay", n, 1 + SETUP);
      chk(pdOut == txBytes[b], "R8 byte order", pdOut, txBytes[b]);
      w = 0;
      while (!strobeN && w < 50) begin
        tick();
        w++;
      end
      chk(w == SWID, "R8 strobe width", w, SWID);
      ok = 1'b1;
      for (int i = 0; i < 4; i++) begin
        tick();
        if (!strobeN || pdOut != txBytes[b]) ok = 1'b0;
      end
      chk(ok, "R8 waits for acknowledge", !ok, 0);
      ackN = 1'b0;
      tick();
      tick();
      ackN = 1'b1;
    end
    tick();
    chk(ecrRdData[0] == 1'b1, "R8 queue drained", ecrRdData[0], 1);

    // R4 illegal direct transition
    ecrWrite(8'hC4);
    chk(ecrRdData == 8'h45, "R4 illegal change ignored", ecrRdData, 8'h45);
    ecrWrite(8'h24);
    ecrWrite(8'hC4);
    chk(ecrRdData[7:5] == 3'b110, "R4 legal change", ecrRdData[7:5], 6);

    // R9 test mode shows head, never strobes
    push(8'h5A);
    push(8'h66);
    ok = 1'b1;
    for (int i = 0; i < 6; i++) begin
      tick();
      if (!strobeN) ok = 1'b0;
    end
    chk(ok, "R9 no strobe in test mode", !ok, 0);
    chk(pdOut == 8'h5A, "R9 head on lines", pdOut, 8'h5A);
    pop(got);
    pop(got);

    // R7 interrupt source select
    faultN = 1'b0;
    tick();
    chk(extIrq == 1'b1, "R7 fault source", extIrq, 1);
    faultN = 1'b1;
    ackN = 1'b0;
    tick();
    chk(extIrq == 1'b0, "R7 ack ignored when fault selected", extIrq, 0);
    ackN = 1'b1;
    ecrWrite(8'hD4);
    ackN = 1'b0;
    tick();
    chk(extIrq == 1'b1, "R7 ack source", extIrq, 1);
    ackN = 1'b1;
    faultN = 1'b0;
    tick();
    chk(extIrq == 1'b0, "R7 fault ignored when ack selected", extIrq, 0);
    faultN = 1'b1;

    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end

endmodule